// File: doc/BRIEF.md
# Software Interrupt Generator

This block decodes one 32-bit write-only command register that lets a CPU raise an interrupt on a chosen group of CPUs. A write carries a 10-bit interrupt number, a 2-bit target filter and an 8-bit explicit CPU list. The block combines the filter with the index of the CPU that issued the write and turns them into a CPU mask. It then gives the distributor's pending logic a one-cycle set-pending strobe, the interrupt number and that mask.

The block takes a plain write strobe with an address, byte enables and a sideband that carries the requesting CPU's index. It stores no pending state and does no arbitration. When the filter field holds the reserved code, the block targets every existing CPU and pulses an error output. When the computed mask is empty, no strobe goes out.

Top module: `swIntGen`

## Requirements
- R1: After reset, `pendStrobe` and `filterErr` are 0, and `pendId` and `pendMask` are all zeros.
- R2: A write is accepted only when `wrEn` is 1, `wrAddr` equals 0xF00 and `wrBe` is 4'b1111. A write that fails any of these conditions produces no strobe and no error, and it leaves `pendId` and `pendMask` unchanged.
- R3: An accepted write whose mask is non-empty raises `pendStrobe` for exactly one cycle, in the cycle after the write is sampled, unless the next write is also accepted.
- R4: With the strobe, `pendId` equals bits 9:0 of the accepted write data.
- R5: Filter value 0 in bits 25:24 gives a mask equal to the list in bits 23:16, cut down to the NUM_CPU CPUs that exist. List bits above the last existing CPU are dropped.
- R6: Filter value 1 gives a mask that holds only the bit of the requesting CPU named on `reqCpu`.
- R7: Filter value 2 gives a mask that holds every existing CPU except the requesting CPU.
- R8: Filter value 3 is reserved. It gives a mask of all existing CPUs, and `filterErr` pulses for one cycle in the same cycle as the strobe.
- R9: When the computed mask is empty, no strobe is issued. This happens, for example, with filter 0 and an empty list, or with a list that names only CPUs that do not exist.
- R10: Accepted writes on consecutive cycles each produce their own strobe on consecutive cycles, and each strobe carries that write's ID and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W (12) | Register offset of the write |
| wrBe | input | 4 | Byte enables of the write |
| wrData | input | 32 | Write data: ID in 9:0, list in 23:16, filter in 25:24 |
| reqCpu | input | CPU_W (2) | Index of the CPU issuing the write |
| pendStrobe | output | 1 | One-cycle set-pending pulse |
| pendId | output | 10 | Interrupt ID to make pending |
| pendMask | output | NUM_CPU (4) | CPUs on which the ID becomes pending |
| filterErr | output | 1 | One-cycle pulse on a reserved filter code |

## Verification
The reserved-filter error and the set-pending strobe are meant to fire together. The bench writes filter code 3 from different requesting CPUs and checks, in the single cycle after each write, that `filterErr` and `pendStrobe` are both high and that the mask is full. It also sends two accepted writes on back-to-back cycles, so that one write is being decoded while the previous strobe is still on the outputs. Each cycle is then checked for its own ID and mask, and the strobe must drop after the second write.

// File: rtl/swIntGenPkg.sv
package swIntGenPkg;

  localparam int ID_W       = 10;
  localparam int LIST_LSB   = 16;
  localparam int FILTER_LSB = 24;
  localparam int DATA_W     = 32;
  localparam int BE_W       = DATA_W / 8;

  // Encoding follows the 2-bit filter field of the command word.
  typedef enum logic [1:0] {
    MODE_LIST     = 2'd0,
    MODE_SELF     = 2'd1,
    MODE_OTHERS   = 2'd2,
    MODE_ALL_RSVD = 2'd3
  } sgiMode_t;

  typedef struct packed {
    logic     accept;
    sgiMode_t mode;
  } sgiStrobes_t;

endpackage

// File: rtl/swIntGenCtrl.sv
module swIntGenCtrl
  import swIntGenPkg::*;
#(
  parameter int               ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hF00
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BE_W-1:0]   wrBe,
  input  logic [1:0]        filterBits,
  output sgiStrobes_t       strobes
);

  logic addrHit;
  logic fullWord;

  assign addrHit  = (wrAddr == REG_OFFSET);
  assign fullWord = &wrBe;

  always_comb begin
    strobes.accept = wrEn && addrHit && fullWord;
    strobes.mode   = sgiMode_t'(filterBits);
  end

endmodule

// File: rtl/swIntGenDatapath.sv
module swIntGenDatapath
  import swIntGenPkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  sgiStrobes_t        strobes,
  input  logic [ID_W-1:0]    idIn,
  input  logic [NUM_CPU-1:0] listIn,
  input  logic [CPU_W-1:0]   reqCpu,
  output logic               pendStrobe,
  output logic [ID_W-1:0]    pendId,
  output logic [NUM_CPU-1:0] pendMask,
  output logic               filterErr
);

  logic [NUM_CPU-1:0] selfMask;
  logic [NUM_CPU-1:0] allMask;
  logic [NUM_CPU-1:0] nextMask;

  assign allMask = {NUM_CPU{1'b1}};

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_self
    assign selfMask[c] = (reqCpu == CPU_W'(c));
  end

  always_comb begin
    unique case (strobes.mode)
      MODE_LIST:     nextMask = listIn;
      MODE_SELF:     nextMask = selfMask;
      MODE_OTHERS:   nextMask = allMask & ~selfMask;
      default:       nextMask = allMask;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendStrobe <= 1'b0;
      filterErr  <= 1'b0;
      pendId     <= '0;
      pendMask   <= '0;
    end else begin
      pendStrobe <= strobes.accept && (|nextMask);
      filterErr  <= strobes.accept && (strobes.mode == MODE_ALL_RSVD);
      if (strobes.accept) begin
        pendId   <= idIn;
        pendMask <= nextMask;
      end
    end
  end

  AST_STROBE_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    pendStrobe |-> (pendMask != '0)); // R9

  AST_ERR_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    filterErr |-> (pendStrobe && (pendMask == allMask))); // R8

  AST_ID_CAPTURED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept |=> (pendId == $past(idIn))); // R4

  AST_SELF_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accept && strobes.mode == MODE_SELF) |=>
      ($countones(pendMask) <= 1)); // R6

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (pendStrobe && !strobes.accept) |=> !pendStrobe); // R3

endmodule

// File: rtl/swIntGen.sv
module swIntGen
  import swIntGenPkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hF00,
  parameter int                NUM_CPU    = 4,
  localparam int               CPU_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [3:0]         wrBe,
  input  logic [31:0]        wrData,
  input  logic [CPU_W-1:0]   reqCpu,
  output logic               pendStrobe,
  output logic [9:0]         pendId,
  output logic [NUM_CPU-1:0] pendMask,
  output logic               filterErr
);

  sgiStrobes_t strobes;
  logic        unusedDataBits;

  assign unusedDataBits = ^wrData;

  swIntGenCtrl #(
    .ADDR_W    (ADDR_W),
    .REG_OFFSET(REG_OFFSET)
  ) ctrl_i (
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrBe      (wrBe),
    .filterBits(wrData[FILTER_LSB +: 2]),
    .strobes   (strobes)
  );

  swIntGenDatapath #(
    .NUM_CPU(NUM_CPU)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .idIn      (wrData[ID_W-1:0]),
    .listIn    (wrData[LIST_LSB +: NUM_CPU]),
    .reqCpu    (reqCpu),
    .pendStrobe(pendStrobe),
    .pendId    (pendId),
    .pendMask  (pendMask),
    .filterErr (filterErr)
  );

endmodule

// File: tb/swIntGen_tb_top.sv
module swIntGen_tb_top;

  localparam int NUM_CPU = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [11:0] wrAddr;
  logic [3:0]  wrBe;
  logic [31:0] wrData;
  logic [1:0]  reqCpu;
  logic        pendStrobe;
  logic [9:0]  pendId;
  logic [3:0]  pendMask;
  logic        filterErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  swIntGen dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrBe(wrBe),
    .wrData(wrData), .reqCpu(reqCpu), .pendStrobe(pendStrobe),
    .pendId(pendId), .pendMask(pendMask), .filterErr(filterErr)
  );

  function automatic logic [31:0] cmd(input logic [1:0] filt,
                                      input logic [7:0] list,
                                      input logic [9:0] id);
    return {6'b0, filt, list, 6'b0, id};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; wrAddr = 12'h000; wrBe = 4'h0; wrData = '0; reqCpu = 2'd0;
  endtask

  // Drive one write, check outputs after the sampling edge and the cycle after.
  task automatic doWrite(input string req, input logic [11:0] a,
                         input logic [3:0] be, input logic [31:0] d,
                         input logic [1:0] cpu, input logic expStb,
                         input logic expErr, input logic [9:0] expId,
                         input logic [3:0] expMask);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrBe = be; wrData = d; reqCpu = cpu;
    @(posedge clk); #1;
    idle();
    check(req, "strobe", 32'(pendStrobe), 32'(expStb));
    check(req, "err", 32'(filterErr), 32'(expErr));
    check(req, "id", 32'(pendId), 32'(expId));
    check(req, "mask", 32'(pendMask), 32'(expMask));
    @(posedge clk); #1;
    check("R3", "strobe drop", 32'(pendStrobe), 32'd0);
    check("R8", "err drop", 32'(filterErr), 32'd0);
  endtask

  task automatic tReset();
    idle(); rstN = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "strobe", 32'(pendStrobe), 0);
    check("R1", "err", 32'(filterErr), 0);
    check("R1", "id", 32'(pendId), 0);
    check("R1", "mask", 32'(pendMask), 0);
    @(negedge clk); rstN = 1;
  endtask

  task automatic tList();
    doWrite("R5", 12'hF00, 4'hF, cmd(2'd0, 8'h05, 10'h123), 2'd3, 1, 0, 10'h123, 4'h5);
    doWrite("R5", 12'hF00, 4'hF, cmd(2'd0, 8'hFA, 10'h3FF), 2'd0, 1, 0, 10'h3FF, 4'hA);
  endtask

  task automatic tSelf();
    for (int c = 0; c < NUM_CPU; c++)
      doWrite("R6", 12'hF00, 4'hF, cmd(2'd1, 8'h00, 10'(c + 7)), 2'(c), 1, 0,
              10'(c + 7), 4'(1 << c));
  endtask

  task automatic tOthers();
    doWrite("R7", 12'hF00, 4'hF, cmd(2'd2, 8'hFF, 10'h010), 2'd1, 1, 0, 10'h010, 4'hD);
    doWrite("R7", 12'hF00, 4'hF, cmd(2'd2, 8'h00, 10'h011), 2'd3, 1, 0, 10'h011, 4'h7);
  endtask

  task automatic tReserved();
    doWrite("R8", 12'hF00, 4'hF, cmd(2'd3, 8'h01, 10'h0AB), 2'd2, 1, 1, 10'h0AB, 4'hF);
    doWrite("R8", 12'hF00, 4'hF, cmd(2'd3, 8'h00, 10'h0AC), 2'd0, 1, 1, 10'h0AC, 4'hF);
  endtask

  task automatic tEmpty();
    doWrite("R9", 12'hF00, 4'hF, cmd(2'd0, 8'h00, 10'h055), 2'd1, 0, 0, 10'h055, 4'h0);
    doWrite("R9", 12'hF00, 4'hF, cmd(2'd0, 8'hF0, 10'h056), 2'd1, 0, 0, 10'h056, 4'h0);
  endtask

  task automatic tIgnored();
    doWrite("R4", 12'hF00, 4'hF, cmd(2'd1, 8'h00, 10'h222), 2'd2, 1, 0, 10'h222, 4'h4);
    doWrite("R2", 12'hF00, 4'h3, cmd(2'd3, 8'h0F, 10'h111), 2'd0, 0, 0, 10'h222, 4'h4);
    doWrite("R2", 12'hF00, 4'h1, cmd(2'd0, 8'h0F, 10'h112), 2'd0, 0, 0, 10'h222, 4'h4);
    doWrite("R2", 12'hF04, 4'hF, cmd(2'd3, 8'h0F, 10'h113), 2'd0, 0, 0, 10'h222, 4'h4);
    @(negedge clk);
    wrEn = 0; wrAddr = 12'hF00; wrBe = 4'hF; wrData = cmd(2'd3, 8'h0F, 10'h114);
    @(posedge clk); #1;
    idle();
    check("R2", "no wrEn strobe", 32'(pendStrobe), 0);
    check("R2", "no wrEn id", 32'(pendId), 32'h222);
  endtask

  task automatic tBackToBack();
    @(negedge clk);
    wrEn = 1; wrAddr = 12'hF00; wrBe = 4'hF; wrData = cmd(2'd1, 8'h00, 10'h301); reqCpu = 2'd0;
    @(posedge clk); #1;
    wrData = cmd(2'd3, 8'h00, 10'h302); reqCpu = 2'd1;
    check("R10", "1st strobe", 32'(pendStrobe), 1);
    check("R10", "1st id", 32'(pendId), 32'h301);
    check("R10", "1st mask", 32'(pendMask), 32'h1);
    check("R10", "1st err", 32'(filterErr), 0);
    @(posedge clk); #1;
    idle();
    check("R10", "2nd strobe", 32'(pendStrobe), 1);
    check("R10", "2nd id", 32'(pendId), 32'h302);
    check("R10", "2nd mask", 32'(pendMask), 32'hF);
    check("R8", "2nd err", 32'(filterErr), 1);
    @(posedge clk); #1;
    check("R3", "strobe end", 32'(pendStrobe), 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    tReset();
    tList();
    tSelf();
    tOthers();
    tReserved();
    tEmpty();
    tIgnored();
    tBackToBack();
    finishRun();
  end

endmodule